// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical timing of a progressive display raster in the pixel clock domain. Two free-running counters, one for the pixel within a line and one for the line within a frame, are compared against programmed limits. The comparisons drive a display-enable strobe and the horizontal and vertical sync pulses, and each sync pulse can be inverted on its own. Near the start of vertical blanking the block raises an interrupt, which software enables, observes and clears through the control word.

Software programs the block through a 32-bit word-addressed register port. Timing words are double-buffered. A new value can be read back at once, but the counters use it only from the next frame boundary, or at once while the engine is stopped. The control registers also carry a pixel-format code and a converter-enable bit for the downstream pixel pipeline, and an interlace bit that is stored and can be read back but does not change the scan. Modes up to 800x600 at a fixed 40 MHz pixel clock fit the 16-bit counter fields.

Top module: `raster_timing_gen`

## Requirements
- R1: After synchronous reset every output is low and every register reads zero.
- R2: The run bit is bit 0 of the control word at word address 0. While it is clear, both counters are held at zero, `de_o` is low and each sync output sits at its inactive level.
- R3: The horizontal timing word at address 2 holds the line length minus one in bits 15:0 and the last visible pixel in bits 31:16. The vertical timing word at address 4 uses the same layout for lines. The pixel counter wraps to zero after it reaches its total, and the line counter advances at each such wrap and wraps after its own total.
- R4: `de_o` is high exactly while the engine runs, the pixel counter is at or below the last visible pixel and the line counter is at or below the last visible line.
- R5: The sync words at addresses 3 (pixels) and 5 (lines) hold the pulse start in bits 15:0 and the end in bits 31:16. A pulse is active while its counter is at or past the start and below the end.
- R6: Control bit 16 inverts `hsync_o` and bit 17 inverts `vsync_o`. The inversion is applied after the pulse window comparison.
- R7: The interrupt status (control bit 31) is set on the first pixel clock of the first line after the last visible line, so it is readable one clock later. `irq_o` is the status ANDed with control bit 30, and the status reads back even while that bit is clear.
- R8: Writing 1 to control bit 31 clears the status, and writing 0 to it leaves the status unchanged.
- R9: A write to a timing word reads back at once. While the engine runs, the counters keep the old value until the last pixel of the current frame, and the new value applies from the next frame onward.
- R10: Control bits 9:7 appear on `pix_fmt_o` (0 RGB565, 1 YUV444, 2 XRGB8888, 3 RGB888, 5 YUV444 to RGB, 7 YUV422). Control bit 3 (interlace) is stored and read back only.
- R11: Bit 0 of the second control word at address 1 drives `dac_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Display enable (visible area) |
| irq_o | output | 1 | Vertical interrupt request |
| dac_en_o | output | 1 | Converter output path enable |
| pix_fmt_o | output | 3 | Pixel format code for downstream logic |

## Verification
On every cycle the assertions check the counter stepping and wrapping, the hold at zero while stopped, the stability of the active timing set inside a frame, the stickiness of the interrupt status until a write clears it, and the gating of `irq_o` and `de_o`. Only the bench scenarios can show the positions of the display-enable and sync edges within a frame, the clock on which the status is set, and the frame on which a shadowed timing write takes effect. The bench also covers polarity inversion, the format and converter outputs, and that writing 0 to the status bit has no effect.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int CW     = 16;
    localparam int DW     = 32;
    localparam int FMT_W  = 3;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_CTRL2 = 3'd1,
        RA_HTIM  = 3'd2,
        RA_HSYN  = 3'd3,
        RA_VTIM  = 3'd4,
        RA_VSYN  = 3'd5
    } reg_addr_e;

    // control word bit positions
    localparam int B_RUN   = 0;
    localparam int B_ILACE = 3;
    localparam int B_FMT   = 7;
    localparam int B_HNEG  = 16;
    localparam int B_VNEG  = 17;
    localparam int B_IEN   = 30;
    localparam int B_ISTS  = 31;

    typedef struct packed {
        cnt_t total;
        cnt_t last_vis;
        cnt_t sync_beg;
        cnt_t sync_end;
    } axis_cfg_t;

    typedef struct packed {
        logic             irq_en;
        logic             vs_neg;
        logic             hs_neg;
        logic [FMT_W-1:0] fmt;
        logic             interlace;
        logic             run;
    } ctrl_t;

    function automatic axis_cfg_t put_lo_hi(input axis_cfg_t c, input logic [DW-1:0] w,
                                            input logic is_sync);
        axis_cfg_t r = c;
        if (is_sync) begin
            r.sync_beg = w[CW-1:0];
            r.sync_end = w[DW-1:CW];
        end else begin
            r.total    = w[CW-1:0];
            r.last_vis = w[DW-1:CW];
        end
        return r;
    endfunction
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      adv,
    input  axis_cfg_t cfg,
    output cnt_t      cnt,
    output logic      at_last,
    output logic      visible,
    output logic      in_sync
);
    assign at_last = (cnt >= cfg.total);
    assign visible = (cnt <= cfg.last_vis);
    assign in_sync = (cnt >= cfg.sync_beg) && (cnt < cfg.sync_end);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + cnt_t'(1);
    end
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_done,
    input  logic          vblank_hit,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic          dac_en,
    output logic          irq_sts,
    output axis_cfg_t     h_act,
    output axis_cfg_t     v_act
);
    axis_cfg_t h_pend, v_pend, h_pend_nxt, v_pend_nxt;
    logic      wr_ctrl, load_act;

    assign wr_ctrl  = wr_en && (addr == RA_CTRL);
    assign load_act = !ctrl.run || frame_done;

    always_comb begin
        h_pend_nxt = h_pend;
        v_pend_nxt = v_pend;
        if (wr_en) begin
            case (addr)
                RA_HTIM: h_pend_nxt = put_lo_hi(h_pend, wdata, 1'b0);
                RA_HSYN: h_pend_nxt = put_lo_hi(h_pend, wdata, 1'b1);
                RA_VTIM: v_pend_nxt = put_lo_hi(v_pend, wdata, 1'b0);
                RA_VSYN: v_pend_nxt = put_lo_hi(v_pend, wdata, 1'b1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_pend  <= '0;
            v_pend  <= '0;
            h_act   <= '0;
            v_act   <= '0;
            ctrl    <= '0;
            dac_en  <= 1'b0;
            irq_sts <= 1'b0;
        end else begin
            h_pend <= h_pend_nxt;
            v_pend <= v_pend_nxt;
            if (load_act) begin
                h_act <= h_pend_nxt;
                v_act <= v_pend_nxt;
            end
            if (wr_ctrl) begin
                ctrl.run       <= wdata[B_RUN];
                ctrl.interlace <= wdata[B_ILACE];
                ctrl.fmt       <= wdata[B_FMT +: FMT_W];
                ctrl.hs_neg    <= wdata[B_HNEG];
                ctrl.vs_neg    <= wdata[B_VNEG];
                ctrl.irq_en    <= wdata[B_IEN];
            end
            if (wr_en && addr == RA_CTRL2)
                dac_en <= wdata[0];
            // a new blanking event wins over a clear in the same clock
            if (vblank_hit)
                irq_sts <= 1'b1;
            else if (wr_ctrl && wdata[B_ISTS])
                irq_sts <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: begin
                rdata[B_RUN]            = ctrl.run;
                rdata[B_ILACE]          = ctrl.interlace;
                rdata[B_FMT +: FMT_W]   = ctrl.fmt;
                rdata[B_HNEG]           = ctrl.hs_neg;
                rdata[B_VNEG]           = ctrl.vs_neg;
                rdata[B_IEN]            = ctrl.irq_en;
                rdata[B_ISTS]           = irq_sts;
            end
            RA_CTRL2: rdata[0] = dac_en;
            RA_HTIM:  rdata = {h_pend.last_vis, h_pend.total};
            RA_HSYN:  rdata = {h_pend.sync_end, h_pend.sync_beg};
            RA_VTIM:  rdata = {v_pend.last_vis, v_pend.total};
            RA_VSYN:  rdata = {v_pend.sync_end, v_pend.sync_beg};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             irq_o,
    output logic             dac_en_o,
    output logic [2:0]       pix_fmt_o
);
    ctrl_t     ctrl;
    axis_cfg_t h_act, v_act;
    cnt_t      h_cnt, v_cnt;
    logic      h_last, v_last, h_vis, v_vis, h_syn, v_syn;
    logic      irq_sts, frame_done, vblank_hit;

    assign frame_done = h_last && v_last;
    assign vblank_hit = ctrl.run && (h_cnt == '0) &&
                        (v_cnt == cnt_t'(v_act.last_vis + cnt_t'(1)));

    rtg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .frame_done(frame_done), .vblank_hit(vblank_hit), .rdata(rdata),
        .ctrl(ctrl), .dac_en(dac_en_o), .irq_sts(irq_sts),
        .h_act(h_act), .v_act(v_act)
    );

    rtg_axis u_hax (
        .clk(clk), .rst(rst), .run(ctrl.run), .adv(1'b1), .cfg(h_act),
        .cnt(h_cnt), .at_last(h_last), .visible(h_vis), .in_sync(h_syn)
    );

    rtg_axis u_vax (
        .clk(clk), .rst(rst), .run(ctrl.run), .adv(h_last), .cfg(v_act),
        .cnt(v_cnt), .at_last(v_last), .visible(v_vis), .in_sync(v_syn)
    );

    assign de_o      = ctrl.run && h_vis && v_vis;
    assign hsync_o   = (ctrl.run && h_syn) ^ ctrl.hs_neg;
    assign vsync_o   = (ctrl.run && v_syn) ^ ctrl.vs_neg;
    assign irq_o     = irq_sts && ctrl.irq_en;
    assign pix_fmt_o = ctrl.fmt;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        run,
    input cnt_t        h_cnt,
    input cnt_t        v_cnt,
    input cnt_t        h_total,
    input axis_cfg_t   h_act,
    input logic        frame_done,
    input logic        irq_sts,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [31:0] wdata,
    input logic        de_o,
    input logic        irq_o
);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h_cnt == '0 && v_cnt == '0));

    a_r2_idle_no_de: assert property (@(posedge clk) disable iff (rst)
        !run |-> !de_o);

    a_r3_pixel_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && h_cnt >= h_total) |=> h_cnt == '0);

    a_r3_pixel_step: assert property (@(posedge clk) disable iff (rst)
        (run && h_cnt < h_total) |=> h_cnt == $past(h_cnt) + cnt_t'(1));

    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_done) |=> $stable(h_act));

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_sts && !(wr_en && addr == 3'd0 && wdata[31])) |=> irq_sts);

    a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_sts);
endmodule

bind raster_timing_gen rtg_checker u_chk (
    .clk(clk), .rst(rst), .run(ctrl.run), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_total(h_act.total), .h_act(h_act), .frame_done(frame_done),
    .irq_sts(irq_sts), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .de_o(de_o), .irq_o(irq_o)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        hsync_o, vsync_o, de_o, irq_o, dac_en_o;
    logic [2:0]  pix_fmt_o;

    int n_cmp = 0;
    int n_bad = 0;
    int pos   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .irq_o(irq_o), .dac_en_o(dac_en_o), .pix_fmt_o(pix_fmt_o)
    );

    // {position in clocks since start, de, hsync, vsync, irq}
    // mode: 10 pixels x 6 lines, visible 6x3, hsync pixels 7..8, vsync lines 3..4
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {12'd0,  4'b1000}, {12'd5,  4'b1000}, {12'd6,  4'b0000},
        {12'd7,  4'b0100}, {12'd9,  4'b0000}, {12'd10, 4'b1000},
        {12'd25, 4'b1000}, {12'd30, 4'b0010}, {12'd31, 4'b0011},
        {12'd38, 4'b0111}, {12'd50, 4'b0001}, {12'd60, 4'b1001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at pos %0d: actual %h expected %h", req, pos, act, exp);
        end
    endtask

    task automatic step_to(input int target);
        while (pos < target) begin
            @(negedge clk);
            pos++;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        pos++;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 outputs", {27'd0, de_o, hsync_o, vsync_o, irq_o, dac_en_o}, 32'd0);
        check("R1 format", {29'd0, pix_fmt_o}, 32'd0);
        rd(3'd0, r); check("R1 ctrl readback", r, 32'd0);
        rd(3'd2, r); check("R1 htim readback", r, 32'd0);

        wr(3'd2, 32'h0005_0009);
        wr(3'd3, 32'h0009_0007);
        wr(3'd4, 32'h0002_0005);
        wr(3'd5, 32'h0005_0003);
        rd(3'd2, r); check("R9 htim readback", r, 32'h0005_0009);
        rd(3'd5, r); check("R9 vsync readback", r, 32'h0005_0003);
        check("R2 stopped outputs", {29'd0, de_o, hsync_o, vsync_o}, 32'd0);

        // run, irq enable, format 2, interlace bit
        wr(3'd0, 32'h4000_0109);
        pos = 0;
        check("R10 format out", {29'd0, pix_fmt_o}, 32'd2);
        rd(3'd0, r); check("R10 ctrl readback with interlace", r, 32'h4000_0109);

        // R3 R4 R5 R7: waveform table
        for (int i = 0; i < NV; i++) begin
            step_to(int'(VEC[i][15:4]));
            check("R3/R4 de", {31'd0, de_o}, {31'd0, VEC[i][3]});
            check("R5 hsync", {31'd0, hsync_o}, {31'd0, VEC[i][2]});
            check("R5 vsync", {31'd0, vsync_o}, {31'd0, VEC[i][1]});
            check("R7 irq", {31'd0, irq_o}, {31'd0, VEC[i][0]});
        end

        // R8: writing 0 to status bit leaves it set
        wr(3'd0, 32'h4000_0109);
        check("R8 write zero keeps irq", {31'd0, irq_o}, 32'd1);
        wr(3'd0, 32'hC000_0109);
        check("R8 clear irq", {31'd0, irq_o}, 32'd0);
        rd(3'd0, r); check("R8 status cleared", {31'd0, r[31]}, 32'd0);

        // irq disabled; new line length written mid-frame
        wr(3'd0, 32'h0000_0109);
        wr(3'd2, 32'h0005_000B);
        rd(3'd2, r); check("R9 immediate readback", r, 32'h0005_000B);
        step_to(70);
        check("R9 old timing holds in frame", {31'd0, de_o}, 32'd1);
        step_to(95);
        check("R7 irq masked", {31'd0, irq_o}, 32'd0);
        rd(3'd0, r); check("R7 status visible while masked", {31'd0, r[31]}, 32'd1);
        step_to(120);
        check("R9 frame boundary", {31'd0, de_o}, 32'd1);
        step_to(130);
        check("R9 new line length pixel 10", {31'd0, de_o}, 32'd0);
        step_to(132);
        check("R9 new line length wrap", {31'd0, de_o}, 32'd1);

        // R6: invert both syncs
        wr(3'd0, 32'h0003_0109);
        step_to(135);
        check("R6 hsync inverted idle", {31'd0, hsync_o}, 32'd1);
        check("R6 vsync inverted idle", {31'd0, vsync_o}, 32'd1);
        step_to(139);
        check("R6 hsync inverted pulse", {31'd0, hsync_o}, 32'd0);

        // R11
        wr(3'd1, 32'h0000_0001);
        check("R11 dac enable", {31'd0, dac_en_o}, 32'd1);

        // R2 R10: stop, format 7
        wr(3'd0, 32'h0000_0380);
        check("R10 format 7", {29'd0, pix_fmt_o}, 32'd7);
        step_to(pos + 8);
        check("R2 stopped after run", {29'd0, de_o, hsync_o, vsync_o}, 32'd0);
        finish_run();
    end
endmodule